// File: doc/BRIEF.md
# NAND Flash Array Emulator

This block is a synthesizable device-side stand-in for a small NAND flash array. Controller benches and prototypes can drive it like a real part. Storage is split into erase blocks. Each block holds a power-of-two number of pages, and each page has a main region followed by a few spare bytes. The block supports three operations: a page read, a page program and a whole-block erase. Programming can only pull bits from 1 to 0. Only an erase brings a block back to all ones.

All traffic passes through one byte-wide bus. Four one-cycle strobes mark each byte as a command, an address byte or a data byte, or request the next read byte. A ready flag stays low while an internal operation runs, and any strobe seen in that time is discarded.

Every block has a saturating erase counter. Once a block has been erased more times than a parameterised endurance limit, every later erase leaves a fixed set of its bits stuck at 0. Blocks chosen by a parameter come out of reset as factory-bad, with a zero marker byte in the spare region of their first page.

Top module: `nand_flash_emu`

## Requirements
- R1: After reset, ready stays low while the array is initialised. When ready rises, every byte reads 0xFF, except that each block flagged in BAD_BLOCKS holds 0x00 at page 0, column MAIN_BYTES (the first spare byte).
- R2: A read is command 0x00, then four address bytes (column low, column high, row low, row high), then command 0x30. From then on io_out shows the byte at (row, column), and each data_re strobe moves to the next column. The column wraps from PAGE_BYTES-1 back to 0. A row holds the page number in its low log2(PAGES) bits and the block number above them.
- R3: A program is command 0x80, then four address bytes in the same order as a read, then data bytes (each one stored at the current column, which then advances and wraps), then command 0x10. Each stored byte becomes the old contents AND the written byte.
- R4: Programming never turns a 0 into a 1. Rewriting a programmed byte leaves the AND of all values written since the last erase.
- R5: An erase is command 0x60, then two row bytes (low, high), then command 0xD0. The block is taken from the row bits above the page field, and the page bits are ignored. Every byte of that block returns to 0xFF, and other blocks do not change.
- R6: After the 0x10 that closes a program, ready is low for exactly T_PROG cycles. After the 0xD0 that closes an erase, ready is low for exactly max(T_ERASE, PAGES*PAGE_BYTES) cycles.
- R7: Every strobe that arrives while ready is low is ignored. It neither starts an operation nor changes the array.
- R8: Each block counts its erases, and the count saturates. The k-th erase of a block with k > ENDURANCE leaves, in every page of that block, the byte at column c (for c a multiple of 8) equal to 0xFF with bit (c/8) mod 8 cleared. All other bytes of the block read 0xFF.
- R9: Any command byte not expected in the current state (including 0x30, 0x10 or 0xD0 sent out of sequence) returns the block to idle without side effects. Outside the read data phase io_out is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | io_in holds a command byte this cycle |
| addr_we | input | 1 | io_in holds an address byte this cycle |
| data_we | input | 1 | io_in holds a program data byte this cycle |
| data_re | input | 1 | Advance to the next read byte |
| io_in | input | 8 | Byte bus into the device |
| io_out | output | 8 | Read data, 0xFF outside the read data phase |
| ready | output | 1 | High when the device accepts strobes |

## Verification
The assertions take for granted that at most one of the four strobes is high in any cycle, and that every address selects a column below PAGE_BYTES. The first of these is checked as a property. The bench drives one strobe per task call, holds each strobe for exactly one clock edge, and only builds column addresses inside the page. Bad-block markers and the worn-bit pattern are checked against values the bench computes from the requirement formulas, while the page sweeps cover every row of the array.

// File: rtl/nand_emu_pkg.sv
package nand_emu_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_ADDR, S_RD_DATA, S_PG_ADDR, S_PG_DATA, S_ER_ADDR
  } fsm_state_e;

  localparam logic [7:0] OP_READ     = 8'h00;
  localparam logic [7:0] OP_READ_GO  = 8'h30;
  localparam logic [7:0] OP_PROG     = 8'h80;
  localparam logic [7:0] OP_PROG_GO  = 8'h10;
  localparam logic [7:0] OP_ERASE    = 8'h60;
  localparam logic [7:0] OP_ERASE_GO = 8'hD0;

  // bits that a worn block can no longer erase, per column
  function automatic logic [7:0] stuck_bits(int unsigned col);
    if (col % 8 == 0) return 8'(1) << ((col / 8) % 8);
    return 8'h00;
  endfunction

  function automatic int unsigned byte_index(int unsigned row, int unsigned col,
                                             int unsigned page_bytes);
    return row * page_bytes + col;
  endfunction

endpackage

// File: rtl/nand_cmd_fsm.sv
module nand_cmd_fsm
  import nand_emu_pkg::*;
#(
  parameter int PAGE_BYTES = 36,
  parameter int PAGES      = 32,
  parameter int BLOCKS     = 4,
  localparam int COL_W = $clog2(PAGE_BYTES),
  localparam int PG_W  = $clog2(PAGES),
  localparam int BLK_W = $clog2(BLOCKS),
  localparam int ROW_W = PG_W + BLK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready,
  input  logic             cmd_we,
  input  logic             addr_we,
  input  logic             data_we,
  input  logic             data_re,
  input  logic [7:0]       io_in,
  output logic             rd_active,
  output logic [ROW_W-1:0] cur_row,
  output logic [COL_W-1:0] cur_col,
  output logic             prog_we,
  output logic             prog_go,
  output logic             erase_go,
  output logic [BLK_W-1:0] erase_blk
);
  fsm_state_e  state;
  logic [2:0]  acnt;
  logic [31:0] sr;
  logic [31:0] sr_next;
  logic        cmd_ok, addr_ok, step;
  logic [ROW_W-1:0] erase_row;

  assign sr_next   = {io_in, sr[31:8]};
  assign cmd_ok    = cmd_we && ready;
  assign addr_ok   = addr_we && ready && acnt < 3'd4 &&
                     (state == S_RD_ADDR || state == S_PG_ADDR || state == S_ER_ADDR);
  assign step      = ready && ((data_we && state == S_PG_DATA) ||
                               (data_re && state == S_RD_DATA));
  assign rd_active = (state == S_RD_DATA);
  assign prog_we   = data_we && ready && state == S_PG_DATA;
  assign prog_go   = cmd_ok && io_in == OP_PROG_GO && state == S_PG_DATA;
  assign erase_go  = cmd_ok && io_in == OP_ERASE_GO && state == S_ER_ADDR && acnt == 3'd2;
  assign erase_row = sr[16 +: ROW_W];
  assign erase_blk = erase_row[ROW_W-1:PG_W];

  function automatic logic [COL_W-1:0] next_col(logic [COL_W-1:0] c);
    return (c == COL_W'(PAGE_BYTES - 1)) ? '0 : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      acnt    <= '0;
      sr      <= '0;
      cur_row <= '0;
      cur_col <= '0;
    end else if (cmd_ok) begin
      acnt <= '0;
      unique case (io_in)
        OP_READ:  state <= S_RD_ADDR;
        OP_PROG:  state <= S_PG_ADDR;
        OP_ERASE: state <= S_ER_ADDR;
        OP_READ_GO: begin
          if (state == S_RD_ADDR && acnt == 3'd4) begin
            state   <= S_RD_DATA;
            cur_col <= sr[COL_W-1:0];
            cur_row <= sr[16 +: ROW_W];
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end else if (addr_ok) begin
      sr   <= sr_next;
      acnt <= acnt + 3'd1;
      if (state == S_PG_ADDR && acnt == 3'd3) begin
        state   <= S_PG_DATA;
        cur_col <= sr_next[COL_W-1:0];
        cur_row <= sr_next[16 +: ROW_W];
      end
    end else if (step) begin
      cur_col <= next_col(cur_col);
    end
  end

  // R7 (input rule: one strobe per cycle)
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_we, addr_we, data_we, data_re}));

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(state) && $stable(cur_col));

endmodule

// File: rtl/nand_wear.sv
module nand_wear #(
  parameter int BLOCKS    = 4,
  parameter int WEAR_W    = 8,
  parameter int ENDURANCE = 3,
  localparam int BLK_W = $clog2(BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             erase_go,
  input  logic [BLK_W-1:0] erase_blk,
  output logic             worn
);
  logic [WEAR_W-1:0] cnt [BLOCKS];

  for (genvar g = 0; g < BLOCKS; g++) begin : g_blk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt[g] <= '0;
      else if (erase_go && erase_blk == BLK_W'(g) && cnt[g] != '1)
        cnt[g] <= cnt[g] + 1'b1;
    end

    // R8
    wear_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[g] == '1 |=> cnt[g] == '1);

    // R8
    wear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(erase_go && erase_blk == BLK_W'(g)) |=> $stable(cnt[g]));
  end

  // a block is worn when it has already seen ENDURANCE erases
  assign worn = 32'(cnt[erase_blk]) >= 32'(ENDURANCE);

endmodule

// File: rtl/nand_array.sv
module nand_array
  import nand_emu_pkg::*;
#(
  parameter int MAIN_BYTES  = 32,
  parameter int PAGE_BYTES  = 36,
  parameter int PAGES       = 32,
  parameter int BLOCKS      = 4,
  parameter int T_PROG      = 20,
  parameter int T_ERASE     = 40,
  parameter logic [BLOCKS-1:0] BAD_BLOCKS = '0,
  localparam int COL_W      = $clog2(PAGE_BYTES),
  localparam int PG_W       = $clog2(PAGES),
  localparam int BLK_W      = $clog2(BLOCKS),
  localparam int ROW_W      = PG_W + BLK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  output logic [7:0]       rd_data,
  input  logic             prog_we,
  input  logic [7:0]       prog_data,
  input  logic             prog_go,
  input  logic             erase_go,
  input  logic [BLK_W-1:0] erase_blk,
  input  logic             erase_worn,
  output logic             ready
);
  localparam int ROWS       = PAGES * BLOCKS;
  localparam int TOTAL      = ROWS * PAGE_BYTES;
  localparam int IDX_W      = $clog2(TOTAL);
  localparam int BLK_BYTES  = PAGES * PAGE_BYTES;
  localparam int ERASE_WAIT = (T_ERASE > BLK_BYTES) ? T_ERASE : BLK_BYTES;
  localparam int WAIT_MAX   = (T_PROG > ERASE_WAIT) ? T_PROG : ERASE_WAIT;
  localparam int CNT_W      = $clog2(WAIT_MAX + 1);

  logic [7:0]       mem [TOTAL];
  logic             walk_on, walk_init, walk_worn;
  logic [ROW_W-1:0] walk_row, walk_last;
  logic [COL_W-1:0] walk_col;
  logic [CNT_W-1:0] busy_cnt;
  logic [7:0]       walk_data, prog_old;
  logic [IDX_W-1:0] walk_idx, acc_idx;
  logic [BLK_W-1:0] walk_blk;

  assign acc_idx  = IDX_W'(byte_index(32'(row), 32'(col), PAGE_BYTES));
  assign walk_idx = IDX_W'(byte_index(32'(walk_row), 32'(walk_col), PAGE_BYTES));
  assign walk_blk = walk_row[ROW_W-1:PG_W];
  assign rd_data  = mem[acc_idx];
  assign prog_old = mem[acc_idx];
  assign ready    = (busy_cnt == '0) && !walk_on;

  always_comb begin
    if (walk_init)
      walk_data = (BAD_BLOCKS[walk_blk] && walk_row[PG_W-1:0] == '0 &&
                   walk_col == COL_W'(MAIN_BYTES)) ? 8'h00 : 8'hFF;
    else if (walk_worn)
      walk_data = ~stuck_bits(32'(walk_col));
    else
      walk_data = 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walk_on   <= 1'b1;
      walk_init <= 1'b1;
      walk_worn <= 1'b0;
      walk_row  <= '0;
      walk_last <= ROW_W'(ROWS - 1);
      walk_col  <= '0;
      busy_cnt  <= '0;
    end else if (erase_go) begin
      walk_on   <= 1'b1;
      walk_init <= 1'b0;
      walk_worn <= erase_worn;
      walk_row  <= {erase_blk, PG_W'(0)};
      walk_last <= {erase_blk, {PG_W{1'b1}}};
      walk_col  <= '0;
      busy_cnt  <= CNT_W'(ERASE_WAIT);
    end else begin
      if (prog_go) busy_cnt <= CNT_W'(T_PROG);
      else if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
      if (walk_on) begin
        if (walk_col == COL_W'(PAGE_BYTES - 1)) begin
          walk_col <= '0;
          if (walk_row == walk_last) walk_on <= 1'b0;
          else walk_row <= walk_row + 1'b1;
        end else begin
          walk_col <= walk_col + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (walk_on) mem[walk_idx] <= walk_data;
    else if (prog_we) mem[acc_idx] <= prog_old & prog_data;
  end

  // R3 / R4
  prog_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |=> ((mem[$past(acc_idx)] & ~$past(prog_old)) == 8'h00));

  // R6
  go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_go || erase_go) |=> !ready);

endmodule

// File: rtl/nand_flash_emu.sv
module nand_flash_emu #(
  parameter int MAIN_BYTES  = 32,
  parameter int SPARE_BYTES = 4,
  parameter int PAGES       = 32,
  parameter int BLOCKS      = 4,
  parameter int WEAR_W      = 8,
  parameter int ENDURANCE   = 3,
  parameter int T_PROG      = 20,
  parameter int T_ERASE     = 40,
  parameter logic [BLOCKS-1:0] BAD_BLOCKS = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic       addr_we,
  input  logic       data_we,
  input  logic       data_re,
  input  logic [7:0] io_in,
  output logic [7:0] io_out,
  output logic       ready
);
  localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES;
  localparam int COL_W      = $clog2(PAGE_BYTES);
  localparam int PG_W       = $clog2(PAGES);
  localparam int BLK_W      = $clog2(BLOCKS);
  localparam int ROW_W      = PG_W + BLK_W;

  logic             rd_active, prog_we, prog_go, erase_go, worn;
  logic [ROW_W-1:0] cur_row;
  logic [COL_W-1:0] cur_col;
  logic [BLK_W-1:0] erase_blk;
  logic [7:0]       rd_data;

  nand_cmd_fsm #(.PAGE_BYTES(PAGE_BYTES), .PAGES(PAGES), .BLOCKS(BLOCKS)) i_fsm (
    .clk, .rst_n, .ready, .cmd_we, .addr_we, .data_we, .data_re, .io_in,
    .rd_active, .cur_row, .cur_col, .prog_we, .prog_go, .erase_go, .erase_blk
  );

  nand_wear #(.BLOCKS(BLOCKS), .WEAR_W(WEAR_W), .ENDURANCE(ENDURANCE)) i_wear (
    .clk, .rst_n, .erase_go, .erase_blk, .worn
  );

  nand_array #(
    .MAIN_BYTES(MAIN_BYTES), .PAGE_BYTES(PAGE_BYTES), .PAGES(PAGES), .BLOCKS(BLOCKS),
    .T_PROG(T_PROG), .T_ERASE(T_ERASE), .BAD_BLOCKS(BAD_BLOCKS)
  ) i_array (
    .clk, .rst_n, .row(cur_row), .col(cur_col), .rd_data,
    .prog_we, .prog_data(io_in), .prog_go, .erase_go, .erase_blk,
    .erase_worn(worn), .ready
  );

  assign io_out = rd_active ? rd_data : 8'hFF;

  // R9
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_active |-> io_out == 8'hFF);

endmodule

// File: tb/test_nand_flash_emu.sv
module test_nand_flash_emu;
  localparam int MAIN = 32, SPARE = 4, PB = MAIN + SPARE, PAGES = 32, BLOCKS = 4;
  localparam int ENDUR = 2, TPROG = 20, TERASE = 40;
  localparam int ROWS = PAGES * BLOCKS, TOTAL = ROWS * PB;
  localparam int EWAIT = (TERASE > PAGES * PB) ? TERASE : PAGES * PB;
  localparam logic [3:0] BAD = 4'b0010;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_we = 0, addr_we = 0, data_we = 0, data_re = 0;
  logic [7:0] io_in = 8'h00, io_out;
  logic ready;
  int checks = 0, errors = 0;
  int model [TOTAL];
  int ecount [BLOCKS];
  logic [7:0] pbuf [PB];

  always #4 clk = ~clk;

  nand_flash_emu #(
    .MAIN_BYTES(MAIN), .SPARE_BYTES(SPARE), .PAGES(PAGES), .BLOCKS(BLOCKS),
    .WEAR_W(3), .ENDURANCE(ENDUR), .T_PROG(TPROG), .T_ERASE(TERASE), .BAD_BLOCKS(BAD)
  ) i_nand_flash_emu (.*);

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // kind: 0 cmd, 1 addr, 2 data write, 3 read advance
  task automatic put(input int kind, input logic [7:0] b);
    @(negedge clk);
    io_in = b;
    cmd_we = (kind == 0); addr_we = (kind == 1);
    data_we = (kind == 2); data_re = (kind == 3);
    @(negedge clk);
    cmd_we = 0; addr_we = 0; data_we = 0; data_re = 0;
  endtask

  task automatic addr4(input int row, input int col);
    put(1, 8'(col)); put(1, 8'(col >> 8)); put(1, 8'(row)); put(1, 8'(row >> 8));
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (!ready && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic read_check(input int row, input int col0, input int n, input string req);
    int bad = 0, first_a = 0, first_e = 0;
    put(0, 8'h00); addr4(row, col0); put(0, 8'h30);
    for (int i = 0; i < n; i++) begin
      int e = model[row * PB + (col0 + i) % PB];
      if (io_out != 8'(e) && bad == 0) begin first_a = io_out; first_e = e; bad = 1; end
      put(3, 8'h00);
    end
    check(first_a, first_e, req);
  endtask

  task automatic prog(input int row, input int col0, input int n, input string req);
    int t;
    put(0, 8'h80); addr4(row, col0);
    for (int i = 0; i < n; i++) begin
      int k = row * PB + (col0 + i) % PB;
      model[k] = model[k] & pbuf[i];
      put(2, pbuf[i]);
    end
    put(0, 8'h10);
    busy_len(t);
    check(t, TPROG, {req, " R6 program busy"});
  endtask

  task automatic erase(input int blk, input int page, input string req);
    int t;
    put(0, 8'h60); put(1, 8'(blk * PAGES + page)); put(1, 8'((blk * PAGES + page) >> 8));
    put(0, 8'hD0);
    ecount[blk]++;
    for (int r = blk * PAGES; r < (blk + 1) * PAGES; r++)
      for (int c = 0; c < PB; c++)
        model[r * PB + c] = (ecount[blk] > ENDUR && c % 8 == 0) ?
                            (8'hFF & ~(1 << ((c / 8) % 8))) : 8'hFF;
    busy_len(t);
    check(t, EWAIT, {req, " R6 erase busy"});
  endtask

  task automatic read_block(input int blk, input string req);
    for (int p = 0; p < PAGES; p++) read_check(blk * PAGES + p, 0, PB, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t;
    for (int i = 0; i < TOTAL; i++) model[i] = 8'hFF;
    for (int b = 0; b < BLOCKS; b++) begin
      ecount[b] = 0;
      if (BAD[b]) model[b * PAGES * PB + MAIN] = 8'h00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready, 0, "R1 ready low during init");
    busy_len(t);
    check(t >= TOTAL - 2 ? 1 : 0, 1, "R1 init length");
    check(io_out, 8'hFF, "R9 idle output");

    // R1 / R2: full sweep of every page
    for (int r = 0; r < ROWS; r++) read_check(r, 0, PB, "R1 R2 sweep");
    read_check(1 * PAGES, MAIN, 1, "R1 bad marker");

    // R3: program a full page
    for (int i = 0; i < PB; i++) pbuf[i] = 8'(i * 7 + 1);
    prog(3, 0, PB, "R3");
    read_check(3, 0, PB, "R3 program page");

    // R4: rewrite cannot set bits
    for (int i = 0; i < PB; i++) pbuf[i] = 8'hF0 ^ 8'(i);
    prog(3, 0, PB, "R4");
    read_check(3, 0, PB, "R4 and of writes");

    // R2: column wrap on program and read
    for (int i = 0; i < 10; i++) pbuf[i] = 8'(8'hA5 ^ (i * 3));
    prog(4, 30, 10, "R2");
    read_check(4, 34, 8, "R2 column wrap");

    // R7: strobes during program busy are ignored
    for (int i = 0; i < PB; i++) pbuf[i] = 8'(i);
    put(0, 8'h80); addr4(64, 0);
    for (int i = 0; i < PB; i++) begin model[64 * PB + i] &= pbuf[i]; put(2, pbuf[i]); end
    put(0, 8'h10);
    put(0, 8'h60); put(1, 8'd64); put(1, 8'd0); put(0, 8'hD0);
    busy_len(t);
    check(t, TPROG - 8, "R7 busy not extended");
    @(negedge clk);
    check(ready, 1, "R7 no erase started");
    read_check(64, 0, PB, "R7 array unchanged");

    // R9: out-of-sequence commands
    put(0, 8'h00); addr4(3, 0); put(0, 8'h55);
    check(io_out, 8'hFF, "R9 unknown command");
    put(0, 8'h30);
    check(io_out, 8'hFF, "R9 confirm without address");
    put(0, 8'hD0);
    busy_len(t);
    check(t, 0, "R9 stray erase confirm");

    // R5: erase block 2 addressed with nonzero page bits
    erase(2, 5, "R5");
    read_block(2, "R5 erased block");
    read_check(3, 0, PB, "R5 other block kept");
    read_check(PAGES, 0, PB, "R5 bad block kept");

    // R8: wear-out of block 3
    for (int k = 1; k <= ENDUR + 2; k++) begin
      for (int i = 0; i < PB; i++) pbuf[i] = 8'h00;
      prog(3 * PAGES + k, 0, PB, "R8");
      erase(3, 0, "R8");
      read_block(3, k > ENDUR ? "R8 stuck bits" : "R8 clean erase");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule